// File: doc/BRIEF.md
# I2C Read Target with Address Hold

This block is an I2C target that only serves read transfers. It watches an open-drain SCL/SDA pair through synchronizers clocked by the system clock. It compares the 7-bit address that follows each START with a configured address, and answers with data bytes that a host CPU loads one at a time. It pulls SCL low at fixed points so that the host can act. Each time it does so it raises a single interrupt flag, which the host clears with a strobe.

With address hold switched on, the target stops after the eighth falling SCL edge of a matching address. The host then looks at the status flags and reads the captured address byte. It chooses ACK or NACK through the ACK-data input, and a release strobe lets the acknowledge clock run. After every acknowledged address or data byte, the target holds SCL again and waits for the next byte and another release. If the controller NACKs a byte, the target lets go of both lines and waits for STOP.

Top module: `i2c_rd_target`

## Requirements
- R1: A START sets `st_start`, and also raises `irq` when `cfg_start_ie` is 1. A STOP clears `st_start`.
- R2: An address byte that does not match `cfg_addr`, or that carries R/W = 0, gets no ACK: SDA stays released on the ninth clock. It also causes no SCL stretch and no interrupt, and leaves `st_buf_full` unchanged. The block then ignores the bus until the next START.
- R3: With `cfg_ahold` = 1 and a matching read address, the following happen once the eighth falling SCL edge has been seen:
  - `scl_pull` is 1 and `st_release` is 0.
  - `irq`, `st_acktim`, `st_rw` and `st_buf_full` are 1, and `st_data` is 0.
  - `host_rdata` equals the address byte {`cfg_addr`, 1'b1}.
- R4: A `host_rd` strobe clears `st_buf_full` in the next cycle.
- R5: With address hold, the ninth-clock bit of the address equals `cfg_ackdt`. A value of 0 pulls SDA low (ACK); a value of 1 leaves SDA high (NACK). After a NACK, the block pulls neither line and raises no further interrupt. Without address hold, the block ACKs a matching read address by itself and does not stretch SCL before the acknowledge.
- R6: A `host_release` strobe sets `st_release`, and `scl_pull` drops in the next cycle.
- R7: After an acknowledged read address or an acknowledged data byte, the following happen once the ninth falling edge has been seen:
  - `st_release` is cleared and SCL is held.
  - `irq` is set and `st_acktim` is 0.
  - Once a data byte has been sent, `st_data` reads 1.
- R8: `host_wr` loads the buffer and sets `st_buf_full` only while the block holds SCL after an acknowledge. A write at any other time leaves `host_rdata` unchanged. `st_buf_full` clears when the loaded byte starts to shift out.
- R9: Data bytes go out MSB first. SDA does not change while SCL is high.
- R10: The bit the controller drives on the ninth clock of a data byte is stored in `st_ackstat` (0 = ACK, 1 = NACK). On ACK the hold and interrupt of R7 follow. On NACK both lines are released, no interrupt is raised, and the block waits for STOP.
- R11: After reset:
  - `scl_pull`, `sda_pull`, `irq` and all status flags except `st_release` are 0.
  - `st_release` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| cfg_addr | input | ADDR_W | Own 7-bit address |
| cfg_ahold | input | 1 | Address hold enable |
| cfg_start_ie | input | 1 | Interrupt on START enable |
| cfg_ackdt | input | 1 | Address acknowledge choice, 1 = NACK |
| host_release | input | 1 | Strobe: set the clock-release bit |
| host_irq_clr | input | 1 | Strobe: clear the interrupt flag |
| host_wr | input | 1 | Strobe: write `host_wdata` to the buffer |
| host_wdata | input | DATA_W | Byte to transmit |
| host_rd | input | 1 | Strobe: buffer read, clears buffer-full |
| host_rdata | output | DATA_W | Buffer contents |
| st_buf_full | output | 1 | Buffer-full flag |
| st_rw | output | 1 | R/W bit of the last matched address |
| st_data | output | 1 | 1 once a data byte has been sent, 0 for address |
| st_acktim | output | 1 | Address acknowledge window active |
| st_start | output | 1 | START seen since the last STOP |
| st_ackstat | output | 1 | Last acknowledge from the controller |
| st_release | output | 1 | Clock-release bit |
| irq | output | 1 | Interrupt flag |

## Verification
The address path is driven with every one of the 128 addresses carrying a read bit, plus the own address carrying a write bit. This separates a correct 7-bit compare and R/W qualification from a partial compare or a compare that ignores R/W. The data path sends all 256 byte values in one long read, each acknowledged except the last. This exposes bit-order, shift-count and SDA-timing faults, and checks that ACK and NACK are told apart. Separate transfers contrast a host ACK with a host NACK of the address, and address hold on with address hold off. This distinguishes the stretch-and-wait behaviour from automatic acknowledgement, and shows that an early buffer write is ignored.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_TXW,
      ST_TX,
      ST_TACK,
      ST_WSTOP
   } tst_e;
endpackage

// File: rtl/i2ct_sync.sv
// Multi-flop synchronizer with edge flags for one bus line; idles high.
module i2ct_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2ct_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign q_o    = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2ct_cond.sv
// START / STOP condition detection from synchronized lines.
module i2ct_cond (
   input  logic scl_q,
   input  logic sda_rise,
   input  logic sda_fall,
   output logic start_ev,
   output logic stop_ev
);
   assign start_ev = scl_q & sda_fall;
   assign stop_ev  = scl_q & sda_rise;
endmodule

// File: rtl/i2ct_core.sv
// Transfer sequencer: address match, hold points, byte shifting, host flags.
module i2ct_core
   import i2ct_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_q,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_ahold,
   input  logic              cfg_start_ie,
   input  logic              cfg_ackdt,
   input  logic              host_release,
   input  logic              host_irq_clr,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   output logic              scl_pull,
   output logic              sda_pull,
   output logic              st_buf_full,
   output logic              st_rw,
   output logic              st_data,
   output logic              st_acktim,
   output logic              st_start,
   output logic              st_ackstat,
   output logic              st_release,
   output logic              irq
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(DATA_W - 1);

   tst_e              state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] buf_q;
   logic              full_q, rw_q, data_q, acktim_q, start_q, ackstat_q;
   logic              rel_q, irq_q, ah_q;
   logic              addr_nack;
   logic              addr_hit;

   assign addr_nack = ah_q & cfg_ackdt;
   assign addr_hit  = (sh_q[DATA_W-1:1] == cfg_addr) & sh_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         sh_q      <= '0;
         buf_q     <= '0;
         full_q    <= 1'b0;
         rw_q      <= 1'b0;
         data_q    <= 1'b0;
         acktim_q  <= 1'b0;
         start_q   <= 1'b0;
         ackstat_q <= 1'b0;
         rel_q     <= 1'b1;
         irq_q     <= 1'b0;
         ah_q      <= 1'b0;
      end else begin
         // host strobes carry the lowest priority
         if (host_release) rel_q  <= 1'b1;
         if (host_irq_clr) irq_q  <= 1'b0;
         if (host_rd)      full_q <= 1'b0;
         if (host_wr && state_q == ST_TXW) begin
            buf_q  <= host_wdata;
            full_q <= 1'b1;
         end

         case (state_q)
            ST_ADDR: begin
               if (scl_rise) begin
                  sh_q  <= {sh_q[DATA_W-2:0], sda_q};
                  cnt_q <= cnt_q + 1'b1;
               end else if (scl_fall && cnt_q == BYTE_END) begin
                  cnt_q <= '0;
                  if (addr_hit) begin
                     state_q  <= ST_AACK;
                     buf_q    <= sh_q;
                     full_q   <= 1'b1;
                     rw_q     <= sh_q[0];
                     data_q   <= 1'b0;
                     acktim_q <= 1'b1;
                     ah_q     <= cfg_ahold;
                     if (cfg_ahold) begin
                        rel_q <= 1'b0;
                        irq_q <= 1'b1;
                     end
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_AACK: begin
               if (scl_fall) begin
                  acktim_q <= 1'b0;
                  if (addr_nack) begin
                     state_q <= ST_WSTOP;
                  end else begin
                     state_q <= ST_TXW;
                     rel_q   <= 1'b0;
                     irq_q   <= 1'b1;
                  end
               end
            end
            ST_TXW: begin
               if (rel_q) begin
                  state_q <= ST_TX;
                  sh_q    <= buf_q;
                  full_q  <= 1'b0;
                  cnt_q   <= '0;
                  data_q  <= 1'b1;
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  sh_q <= {sh_q[DATA_W-2:0], 1'b0};
                  if (cnt_q == LAST_TX) begin
                     state_q <= ST_TACK;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_TACK: begin
               if (scl_rise) begin
                  ackstat_q <= sda_q;
               end else if (scl_fall) begin
                  if (!ackstat_q) begin
                     state_q <= ST_TXW;
                     rel_q   <= 1'b0;
                     irq_q   <= 1'b1;
                  end else begin
                     state_q <= ST_WSTOP;
                  end
               end
            end
            default: ;
         endcase

         if (start_ev) begin
            state_q  <= ST_ADDR;
            cnt_q    <= '0;
            sh_q     <= '0;
            start_q  <= 1'b1;
            data_q   <= 1'b0;
            acktim_q <= 1'b0;
            rel_q    <= 1'b1;
            if (cfg_start_ie) irq_q <= 1'b1;
         end else if (stop_ev) begin
            state_q  <= ST_IDLE;
            start_q  <= 1'b0;
            acktim_q <= 1'b0;
            rel_q    <= 1'b1;
         end
      end
   end

   always_comb begin
      sda_pull = 1'b0;
      case (state_q)
         ST_AACK: sda_pull = ~addr_nack;
         ST_TXW:  sda_pull = ~buf_q[DATA_W-1];
         ST_TX:   sda_pull = ~sh_q[DATA_W-1];
         default: sda_pull = 1'b0;
      endcase
   end

   assign scl_pull    = ~rel_q & ((state_q == ST_AACK) | (state_q == ST_TXW));
   assign host_rdata  = buf_q;
   assign st_buf_full = full_q;
   assign st_rw       = rw_q;
   assign st_data     = data_q;
   assign st_acktim   = acktim_q;
   assign st_start    = start_q;
   assign st_ackstat  = ackstat_q;
   assign st_release  = rel_q;
   assign irq         = irq_q;
endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target #(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_pull,
   output logic              sda_pull,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_ahold,
   input  logic              cfg_start_ie,
   input  logic              cfg_ackdt,
   input  logic              host_release,
   input  logic              host_irq_clr,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   output logic              st_buf_full,
   output logic              st_rw,
   output logic              st_data,
   output logic              st_acktim,
   output logic              st_start,
   output logic              st_ackstat,
   output logic              st_release,
   output logic              irq
);
   localparam int N_LINES = 2;
   localparam int L_SCL   = 0;
   localparam int L_SDA   = 1;

   if (DATA_W != ADDR_W + 1) begin : g_bad_width
      $error("i2c_rd_target: DATA_W must equal ADDR_W + 1");
   end

   logic [N_LINES-1:0] line_in, line_q, line_rise, line_fall;
   logic               start_ev, stop_ev;

   assign line_in[L_SCL] = scl_i;
   assign line_in[L_SDA] = sda_i;

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .d_i    (line_in[g]),
         .q_o    (line_q[g]),
         .rise_o (line_rise[g]),
         .fall_o (line_fall[g])
      );
   end

   i2ct_cond u_cond (
      .scl_q    (line_q[L_SCL]),
      .sda_rise (line_rise[L_SDA]),
      .sda_fall (line_fall[L_SDA]),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   i2ct_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_rise     (line_rise[L_SCL]),
      .scl_fall     (line_fall[L_SCL]),
      .sda_q        (line_q[L_SDA]),
      .start_ev     (start_ev),
      .stop_ev      (stop_ev),
      .cfg_addr     (cfg_addr),
      .cfg_ahold    (cfg_ahold),
      .cfg_start_ie (cfg_start_ie),
      .cfg_ackdt    (cfg_ackdt),
      .host_release (host_release),
      .host_irq_clr (host_irq_clr),
      .host_wr      (host_wr),
      .host_wdata   (host_wdata),
      .host_rd      (host_rd),
      .host_rdata   (host_rdata),
      .scl_pull     (scl_pull),
      .sda_pull     (sda_pull),
      .st_buf_full  (st_buf_full),
      .st_rw        (st_rw),
      .st_data      (st_data),
      .st_acktim    (st_acktim),
      .st_start     (st_start),
      .st_ackstat   (st_ackstat),
      .st_release   (st_release),
      .irq          (irq)
   );
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic scl_pull,
   input logic sda_pull,
   input logic irq,
   input logic st_release,
   input logic st_acktim,
   input logic st_data,
   input logic st_start,
   input logic st_buf_full,
   input logic host_rd,
   input logic host_wr
);
   AST_HOLD_ONLY_UNRELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      scl_pull |-> !st_release); // R6
   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_i); // R9
   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (scl_pull || $rose(st_start))); // R7
   AST_ACKTIM_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      st_acktim |-> !st_data); // R3
   AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr) |=> !st_buf_full); // R4
endmodule

bind i2c_rd_target i2ct_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_i       (scl_i),
   .scl_pull    (scl_pull),
   .sda_pull    (sda_pull),
   .irq         (irq),
   .st_release  (st_release),
   .st_acktim   (st_acktim),
   .st_data     (st_data),
   .st_start    (st_start),
   .st_buf_full (st_buf_full),
   .host_rd     (host_rd),
   .host_wr     (host_wr)
);

// File: tb/i2c_rd_target_tb.sv
module i2c_rd_target_tb;
   localparam int H = 6;
   localparam logic [6:0] MY = 7'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic tb_scl_low = 1'b0, tb_sda_low = 1'b0;
   logic scl_line, sda_line, scl_pull, sda_pull;
   logic cfg_ahold = 1'b1, cfg_start_ie = 1'b1, cfg_ackdt = 1'b0;
   logic host_release = 1'b0, host_irq_clr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = 8'h00, host_rdata;
   logic st_buf_full, st_rw, st_data, st_acktim, st_start, st_ackstat, st_release, irq;

   assign scl_line = ~(tb_scl_low | scl_pull);
   assign sda_line = ~(tb_sda_low | sda_pull);

   i2c_rd_target u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_pull(scl_pull), .sda_pull(sda_pull), .cfg_addr(MY),
      .cfg_ahold(cfg_ahold), .cfg_start_ie(cfg_start_ie), .cfg_ackdt(cfg_ackdt),
      .host_release(host_release), .host_irq_clr(host_irq_clr),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
      .host_rdata(host_rdata), .st_buf_full(st_buf_full), .st_rw(st_rw),
      .st_data(st_data), .st_acktim(st_acktim), .st_start(st_start),
      .st_ackstat(st_ackstat), .st_release(st_release), .irq(irq)
   );

   int checks = 0;
   int fails  = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_scl_high();
      while (!scl_line) @(negedge clk);
   endtask

   task automatic do_release();
      host_release = 1'b1; @(negedge clk); host_release = 1'b0;
   endtask
   task automatic do_clr();
      host_irq_clr = 1'b1; @(negedge clk); host_irq_clr = 1'b0;
   endtask
   task automatic do_rd();
      host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
   endtask
   task automatic do_wr(input logic [7:0] v);
      host_wdata = v; host_wr = 1'b1; @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic bus_start();
      tb_sda_low = 1'b1; tick(H);
      tb_scl_low = 1'b1; tick(H);
   endtask

   task automatic bus_stop();
      tb_sda_low = 1'b1; tick(H);
      tb_scl_low = 1'b0; wait_scl_high(); tick(H);
      tb_sda_low = 1'b0; tick(H);
   endtask

   task automatic send_bit(input logic b);
      tb_sda_low = ~b; tick(H);
      tb_scl_low = 1'b0; wait_scl_high(); tick(H);
      tb_scl_low = 1'b1; tick(H);
   endtask

   task automatic read_bit(output logic b);
      logic first;
      tb_sda_low = 1'b0; tick(H);
      tb_scl_low = 1'b0; wait_scl_high(); tick(1);
      first = sda_line;
      tick(H - 1);
      check("R9 sda stable while scl high", {31'd0, sda_line}, {31'd0, first});
      b = sda_line;
      tb_scl_low = 1'b1; tick(H);
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic read_byte(output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         read_bit(b);
         v[i] = b;
      end
   endtask

   task automatic run_nomatch(input logic [7:0] abyte);
      logic b;
      bus_start();
      check("R1 start flag", {31'd0, st_start}, 32'd1);
      check("R1 start irq", {31'd0, irq}, 32'd1);
      do_clr();
      send_byte(abyte);
      check("R2 no stretch", {31'd0, scl_pull}, 32'd0);
      read_bit(b);
      check("R2 no ack", {31'd0, b}, 32'd1);
      check("R2 no irq", {31'd0, irq}, 32'd0);
      check("R2 buffer full untouched", {31'd0, st_buf_full}, 32'd0);
      bus_stop();
      check("R1 stop clears start", {31'd0, st_start}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic b;
      logic [7:0] got;
      tick(4);
      rst_n = 1'b1;
      tick(2);
      // R11 reset state
      check("R11 scl_pull", {31'd0, scl_pull}, 32'd0);
      check("R11 sda_pull", {31'd0, sda_pull}, 32'd0);
      check("R11 irq", {31'd0, irq}, 32'd0);
      check("R11 release", {31'd0, st_release}, 32'd1);
      check("R11 flags", {26'd0, st_buf_full, st_rw, st_data, st_acktim, st_start, st_ackstat}, 32'd0);

      // R2 sweep: every address with read bit, plus own address with write bit
      for (int a = 0; a < 128; a++)
         if (7'(a) != MY) run_nomatch({7'(a), 1'b1});
      run_nomatch({MY, 1'b0});

      // Address hold, host ACK, all 256 data bytes
      cfg_start_ie = 1'b0;
      bus_start();
      check("R1 no irq when disabled", {31'd0, irq}, 32'd0);
      send_byte({MY, 1'b1});
      check("R3 scl held", {31'd0, scl_pull}, 32'd1);
      check("R3 release cleared", {31'd0, st_release}, 32'd0);
      check("R3 irq", {31'd0, irq}, 32'd1);
      check("R3 acktim", {31'd0, st_acktim}, 32'd1);
      check("R3 rw", {31'd0, st_rw}, 32'd1);
      check("R3 data/addr", {31'd0, st_data}, 32'd0);
      check("R3 full", {31'd0, st_buf_full}, 32'd1);
      check("R3 address byte", {24'd0, host_rdata}, {24'd0, MY, 1'b1});
      do_wr(8'h33);
      check("R8 early write ignored", {24'd0, host_rdata}, {24'd0, MY, 1'b1});
      do_rd();
      check("R4 read clears full", {31'd0, st_buf_full}, 32'd0);
      do_clr();
      cfg_ackdt = 1'b0;
      tick(1);
      check("R5 ack driven while held", {31'd0, sda_pull}, 32'd1);
      do_release();
      check("R6 release bit", {31'd0, st_release}, 32'd1);
      check("R6 scl let go", {31'd0, scl_pull}, 32'd0);
      read_bit(b);
      check("R5 address ack", {31'd0, b}, 32'd0);
      check("R7 irq after address", {31'd0, irq}, 32'd1);
      check("R7 scl held", {31'd0, scl_pull}, 32'd1);
      check("R7 acktim cleared", {31'd0, st_acktim}, 32'd0);
      for (int i = 0; i < 256; i++) begin
         logic last;
         last = (i == 255);
         do_clr();
         do_wr(8'(i));
         check("R8 write sets full", {31'd0, st_buf_full}, 32'd1);
         check("R8 buffer loaded", {24'd0, host_rdata}, i);
         do_release();
         read_byte(got);
         check("R9 byte msb first", {24'd0, got}, i);
         send_bit(last);
         check("R10 ackstat", {31'd0, st_ackstat}, {31'd0, last});
         if (!last) begin
            check("R7 irq after byte", {31'd0, irq}, 32'd1);
            check("R7 scl held after byte", {31'd0, scl_pull}, 32'd1);
            check("R7 data flag", {31'd0, st_data}, 32'd1);
         end else begin
            check("R10 no irq after nack", {31'd0, irq}, 32'd0);
            check("R10 scl free after nack", {31'd0, scl_pull}, 32'd0);
            check("R10 sda free after nack", {31'd0, sda_pull}, 32'd0);
         end
      end
      bus_stop();
      check("R1 stop clears start", {31'd0, st_start}, 32'd0);

      // Address hold with host NACK
      bus_start();
      send_byte({MY, 1'b1});
      check("R3 irq on hold", {31'd0, irq}, 32'd1);
      do_clr();
      cfg_ackdt = 1'b1;
      do_release();
      read_bit(b);
      check("R5 host nack", {31'd0, b}, 32'd1);
      check("R5 no hold after nack", {31'd0, scl_pull}, 32'd0);
      check("R5 no irq after nack", {31'd0, irq}, 32'd0);
      bus_stop();
      cfg_ackdt = 1'b0;

      // Address hold off: automatic ACK, hold only after acknowledge
      cfg_ahold = 1'b0;
      bus_start();
      send_byte({MY, 1'b1});
      check("R5 no stretch without hold", {31'd0, scl_pull}, 32'd0);
      check("R5 no irq without hold", {31'd0, irq}, 32'd0);
      check("R5 auto ack driven", {31'd0, sda_pull}, 32'd1);
      read_bit(b);
      check("R5 auto ack", {31'd0, b}, 32'd0);
      check("R7 irq after auto ack", {31'd0, irq}, 32'd1);
      check("R7 hold after auto ack", {31'd0, scl_pull}, 32'd1);
      do_clr();
      do_wr(8'h3C);
      do_release();
      tick(1);
      check("R8 full cleared on shift start", {31'd0, st_buf_full}, 32'd0);
      read_byte(got);
      check("R9 byte 3C", {24'd0, got}, 32'h3C);
      send_bit(1'b1);
      check("R10 nack captured", {31'd0, st_ackstat}, 32'd1);
      bus_stop();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule